// File: doc/BRIEF.md
# Asynchronous Serial Interface Register and Interrupt Core

This block is the processor-facing half of a byte-oriented asynchronous serial port. A four-location bus port gives the processor access to these locations:

- a data location. A read returns the received byte and a write loads the byte to send.
- a status location. A read reports flags and a write of any value performs a programmed reset.
- a command location that holds the interrupt, handshake and frame settings.
- a control location that holds the rate and frame settings.

The bit serializers sit outside the block. Received bytes arrive over a valid/ready handshake and bytes to send leave over one. The stored rate and frame fields are driven out to the serializers.

The block drives active-low interrupt, data-terminal-ready and request-to-send outputs. It samples three active-low modem inputs through synchronizers: carrier detect, data-set-ready and clear-to-send. Carrier detect and data-set-ready do not gate the receiver. Their levels are only reported and watched for changes. Clear-to-send holds back the transmitter and hides the transmit-empty flag. Every edge on the two watched lines raises an interrupt while the master enable is set, whatever the per-direction interrupt settings are.

Top module: `acia_core`

## Requirements
- R1: After hardware reset the command and control locations read 0x00, status reads 0x10 while both watched modem inputs are low, and irq_no, dtr_no and rts_no are all high.
- R2: The control location (offset 3) reads back all eight bits as written. Bit 7 drives stop_sel_o, bits 6:5 drive word_len_o, bit 4 drives clk_int_o and bits 3:0 drive rate_sel_o. A programmed reset leaves the control location unchanged.
- R3: The command location (offset 2) reads back as written. Bits 7:5 drive par_mode_o, bit 4 drives echo_o, and bit 0 is the master enable, with dtr_no equal to its inverse. Bits 3:2 equal to 00 drive rts_no high and any other value drives it low.
- R4: Any write to offset 1 clears command bits 4:0, keeps command bits 7:5, and clears status bit 2, status bit 7 and any pending line change. This leaves dtr_no high and the receiver not ready.
- R5: While the master enable is set, rx_ready_o is high. A byte taken on rx_valid_i reads at offset 0 and sets status bit 3, and reading offset 0 clears bit 3. While the master enable is clear, rx_ready_o is low and offered bytes are dropped.
- R6: Status bit 1 (framing) and bit 0 (parity) take the receiver's flags with each byte. Bit 2 (overrun) is set when a byte arrives while bit 3 is still set. The next byte overwrites all three flags.
- R7: Writing offset 0 clears status bit 4 and presents the byte on tx_data_o with tx_valid_o. A cycle with tx_valid_o and tx_ready_i sets bit 4 again and drops tx_valid_o.
- R8: While cts_ni is high, tx_valid_o is low and status bit 4 reads 0. Transmission resumes when cts_ni returns low.
- R9: Status bit 6 reports the synchronized level of dcd_ni and bit 5 the level of dsr_ni. A high level reads as 1.
- R10: With the master enable set and command bit 1 at 0, a set status bit 3 drives irq_no low. irq_no returns high within one clock of the last pending source clearing.
- R11: With the master enable set and command bits 3:2 at 01, a set status bit 4 drives irq_no low.
- R12: With the master enable set, any edge on dcd_ni or dsr_ni drives irq_no low regardless of command bits 3:1. A status read clears the condition.
- R13: With the master enable clear, irq_no stays high, and line edges seen during that time are not remembered.
- R14: Status bit 7 is set while any enabled source is pending and stays set until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (read side effects) |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_no | output | 1 | Interrupt request, active low |
| dtr_no | output | 1 | Data terminal ready, active low |
| rts_no | output | 1 | Request to send, active low |
| dcd_ni | input | 1 | Carrier detect, active low |
| dsr_ni | input | 1 | Data set ready, active low |
| cts_ni | input | 1 | Clear to send, active low |
| rx_valid_i | input | 1 | Receiver byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_frame_err_i | input | 1 | Framing error of offered byte |
| rx_par_err_i | input | 1 | Parity error of offered byte |
| rx_ready_o | output | 1 | Receiver enabled, byte accepted |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmitter takes the byte |
| par_mode_o | output | 3 | Parity mode field |
| echo_o | output | 1 | Echo mode field |
| stop_sel_o | output | 1 | Stop-bit select |
| word_len_o | output | 2 | Word length field |
| clk_int_o | output | 1 | Internal rate generator select |
| rate_sel_o | output | 4 | Rate select field |

## Verification
The hardest state to reach is a line edge that arrives while the master enable is clear and must leave no trace afterwards. The bench gets there in three steps. It first clears the enable and toggles carrier detect. It then waits through the synchronizer latency and sets the enable again, and finally checks that irq_no stays high and that status shows only the new level. Overrun is reached by offering two bytes back to back with no data read between them, followed by a programmed reset. The bench then checks that overrun clears while the held byte and the full flag survive.

// File: rtl/acia_pkg.sv
package acia_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  typedef enum logic [AW-1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CMD  = 2'd2,
    REG_CTL  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] par;
    logic       echo;
    logic [1:0] txc;
    logic       rx_irq_off;
    logic       master;
  } cmd_t;

  typedef struct packed {
    logic       stop;
    logic [1:0] wlen;
    logic       clk_int;
    logic [3:0] rate;
  } ctl_t;

  localparam logic [1:0] TXC_RTS_HI = 2'b00;
  localparam logic [1:0] TXC_IRQ_ON = 2'b01;
  localparam int SOFT_KEEP = 5; // command bits at and above survive programmed reset
endpackage

// File: rtl/acia_sync.sv
module acia_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/acia_cfg_regs.sv
module acia_cfg_regs
  import acia_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          ctl_we_i,
  input  logic          soft_rst_i,
  input  logic [DW-1:0] wdata_i,
  output cmd_t          cmd_o,
  output ctl_t          ctl_o
);
  logic [DW-1:0] cmd_q, ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      ctl_q <= '0;
    end else begin
      if (soft_rst_i)    cmd_q <= {cmd_q[DW-1:SOFT_KEEP], {SOFT_KEEP{1'b0}}};
      else if (cmd_we_i) cmd_q <= wdata_i;
      if (ctl_we_i)      ctl_q <= wdata_i;
    end
  end

  assign cmd_o = cmd_t'(cmd_q);
  assign ctl_o = ctl_t'(ctl_q);
endmodule

// File: rtl/acia_rx_hold.sv
module acia_rx_hold
  import acia_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          soft_rst_i,
  input  logic          rd_data_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_fe_i,
  input  logic          rx_pe_i,
  output logic          rx_ready_o,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          ovr_o,
  output logic          fe_o,
  output logic          pe_o
);
  logic accept;
  assign rx_ready_o = en_i;
  assign accept     = rx_valid_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
    end else if (accept) begin
      data_o <= rx_data_i;
      fe_o   <= rx_fe_i;
      pe_o   <= rx_pe_i;
      ovr_o  <= full_o & ~rd_data_i; // byte still unread is lost
      full_o <= 1'b1;
    end else begin
      if (rd_data_i)  full_o <= 1'b0;
      if (soft_rst_i) ovr_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/acia_irq_ctl.sv
module acia_irq_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic       rx_src_i,
  input  logic       tx_src_i,
  input  logic [1:0] lines_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       irq_no
);
  logic [1:0] lines_q;
  logic       chg, pend_q, src_any, irq_q;

  assign chg     = |(lines_i ^ lines_q);
  assign src_any = master_i & (rx_src_i | tx_src_i | pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q <= '1;
      pend_q  <= 1'b0;
      flag_o  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      lines_q <= lines_i;
      if (chg & master_i) pend_q <= 1'b1;
      else if (clr_i)     pend_q <= 1'b0;
      flag_o <= clr_i ? 1'b0 : (flag_o | src_any);
      irq_q  <= src_any;
    end
  end

  assign irq_no = ~irq_q;
endmodule

// File: rtl/acia_core.sv
module acia_core
  import acia_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no,
  output logic          dtr_no,
  output logic          rts_no,
  input  logic          dcd_ni,
  input  logic          dsr_ni,
  input  logic          cts_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_frame_err_i,
  input  logic          rx_par_err_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  output logic [2:0]    par_mode_o,
  output logic          echo_o,
  output logic          stop_sel_o,
  output logic [1:0]    word_len_o,
  output logic          clk_int_o,
  output logic [3:0]    rate_sel_o
);
  reg_sel_e sel;
  logic     wr, rd, soft_rst, rd_data, rd_stat;
  cmd_t     cmd;
  ctl_t     ctl;
  logic [2:0] modem_s;
  logic     dcd_s, dsr_s, cts_s;
  logic     rx_full, rx_ovr, rx_fe, rx_pe;
  logic [DW-1:0] rx_byte;
  logic     tx_empty_q, tdre, irq_flag;

  assign sel      = reg_sel_e'(addr_i);
  assign wr       = cs_i & we_i;
  assign rd       = cs_i & re_i & ~we_i;
  assign soft_rst = wr & (sel == REG_STAT);
  assign rd_data  = rd & (sel == REG_DATA);
  assign rd_stat  = rd & (sel == REG_STAT);

  acia_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cts_ni, dsr_ni, dcd_ni}),
    .q_o   (modem_s)
  );
  assign {cts_s, dsr_s, dcd_s} = modem_s;

  acia_cfg_regs u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (wr & (sel == REG_CMD)),
    .ctl_we_i  (wr & (sel == REG_CTL)),
    .soft_rst_i(soft_rst),
    .wdata_i   (wdata_i),
    .cmd_o     (cmd),
    .ctl_o     (ctl)
  );

  acia_rx_hold u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cmd.master),
    .soft_rst_i(soft_rst),
    .rd_data_i (rd_data),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .rx_fe_i   (rx_frame_err_i),
    .rx_pe_i   (rx_par_err_i),
    .rx_ready_o(rx_ready_o),
    .data_o    (rx_byte),
    .full_o    (rx_full),
    .ovr_o     (rx_ovr),
    .fe_o      (rx_fe),
    .pe_o      (rx_pe)
  );

  // transmit holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_empty_q <= 1'b1;
      tx_data_o  <= '0;
    end else if (wr && sel == REG_DATA) begin
      tx_empty_q <= 1'b0;
      tx_data_o  <= wdata_i;
    end else if (tx_valid_o && tx_ready_i) begin
      tx_empty_q <= 1'b1;
    end
  end

  assign tx_valid_o = ~tx_empty_q & ~cts_s;
  assign tdre       = tx_empty_q & ~cts_s;

  acia_irq_ctl u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(cmd.master),
    .rx_src_i(~cmd.rx_irq_off & rx_full),
    .tx_src_i((cmd.txc == TXC_IRQ_ON) & tdre),
    .lines_i ({dcd_s, dsr_s}),
    .clr_i   (rd_stat | soft_rst),
    .flag_o  (irq_flag),
    .irq_no  (irq_no)
  );

  always_comb begin
    unique case (sel)
      REG_DATA: rdata_o = rx_byte;
      REG_STAT: rdata_o = {irq_flag, dcd_s, dsr_s, tdre, rx_full, rx_ovr, rx_fe, rx_pe};
      REG_CMD:  rdata_o = cmd;
      default:  rdata_o = ctl;
    endcase
  end

  assign dtr_no     = ~cmd.master;
  assign rts_no     = (cmd.txc == TXC_RTS_HI);
  assign par_mode_o = cmd.par;
  assign echo_o     = cmd.echo;
  assign stop_sel_o = ctl.stop;
  assign word_len_o = ctl.wlen;
  assign clk_int_o  = ctl.clk_int;
  assign rate_sel_o = ctl.rate;
endmodule

// File: rtl/acia_core_chk.sv
module acia_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [3:0] wd_rate_i,
  input logic [1:0] wd_txc_i,
  input logic       irq_no,
  input logic       dtr_no,
  input logic       rts_no,
  input logic       rx_ready_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic [3:0] rate_sel_o
);
  // R4
  soft_rst_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == 2'd1) |=> (dtr_no && !rx_ready_o));

  // R13
  master_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dtr_no && $past(dtr_no)) |-> irq_no);

  // R7
  tx_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !(cs_i && we_i && addr_i == 2'd0)) |=> !tx_valid_o);

  // R3
  rts_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == 2'd2) |=> (rts_no == ($past(wd_txc_i) == 2'b00)));

  // R2
  rate_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i && addr_i == 2'd3) |=> (rate_sel_o == $past(wd_rate_i)));
endmodule

bind acia_core acia_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wd_rate_i (wdata_i[3:0]),
  .wd_txc_i  (wdata_i[3:2]),
  .irq_no    (irq_no),
  .dtr_no    (dtr_no),
  .rts_no    (rts_no),
  .rx_ready_o(rx_ready_o),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .rate_sel_o(rate_sel_o)
);

// File: tb/sim_acia_core.sv
module sim_acia_core;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_no, dtr_no, rts_no;
  logic       dcd_ni = 1'b0, dsr_ni = 1'b0, cts_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_frame_err_i = 1'b0, rx_par_err_i = 1'b0;
  logic       rx_ready_o, tx_valid_o, tx_ready_i = 1'b0;
  logic [7:0] tx_data_o;
  logic [2:0] par_mode_o;
  logic       echo_o, stop_sel_o, clk_int_o;
  logic [1:0] word_len_o;
  logic [3:0] rate_sel_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acia_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .re_i(re_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_no(irq_no), .dtr_no(dtr_no), .rts_no(rts_no),
    .dcd_ni(dcd_ni), .dsr_ni(dsr_ni), .cts_ni(cts_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_frame_err_i(rx_frame_err_i), .rx_par_err_i(rx_par_err_i),
    .rx_ready_o(rx_ready_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .tx_ready_i(tx_ready_i), .par_mode_o(par_mode_o), .echo_o(echo_o),
    .stop_sel_o(stop_sel_o), .word_len_o(word_len_o), .clk_int_o(clk_int_o),
    .rate_sel_o(rate_sel_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    cs_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1; re_i = 1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 0; re_i = 0;
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk);
    rx_valid_i = 1; rx_data_i = d; rx_frame_err_i = fe; rx_par_err_i = pe;
    @(negedge clk);
    rx_valid_i = 0; rx_frame_err_i = 0; rx_par_err_i = 0;
  endtask

  task automatic tx_take();
    @(negedge clk);
    tx_ready_i = 1;
    @(negedge clk);
    tx_ready_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq_no", {7'd0, irq_no}, 8'h01);
    chk("R1 dtr_no", {7'd0, dtr_no}, 8'h01);
    chk("R1 rts_no", {7'd0, rts_no}, 8'h01);
    rd(2'd1, v); chk("R1 R9 status", v, 8'h10);
    rd(2'd2, v); chk("R1 command", v, 8'h00);
    rd(2'd3, v); chk("R1 control", v, 8'h00);
  endtask

  task automatic t_ctl();
    logic [7:0] v;
    wr(2'd3, 8'h9A);
    rd(2'd3, v); chk("R2 readback", v, 8'h9A);
    chk("R2 fields", {stop_sel_o, word_len_o, clk_int_o, rate_sel_o}, 8'h9A);
    wr(2'd3, 8'h65);
    chk("R2 fields2", {stop_sel_o, word_len_o, clk_int_o, rate_sel_o}, 8'h65);
    wr(2'd3, 8'h9A);
  endtask

  task automatic t_cmd();
    logic [7:0] v;
    wr(2'd2, 8'hB9);
    rd(2'd2, v); chk("R3 readback", v, 8'hB9);
    chk("R3 par/echo", {4'd0, par_mode_o, echo_o}, 8'h0B);
    chk("R3 dtr low", {7'd0, dtr_no}, 8'h00);
    chk("R3 rts low txc10", {7'd0, rts_no}, 8'h00);
    wr(2'd2, 8'h01);
    chk("R3 rts high txc00", {7'd0, rts_no}, 8'h01);
    wr(2'd2, 8'h0C);
    chk("R3 rts low txc11", {7'd0, rts_no}, 8'h00);
    chk("R3 dtr high", {7'd0, dtr_no}, 8'h01);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    wr(2'd2, 8'h03);
    chk("R5 ready", {7'd0, rx_ready_o}, 8'h01);
    rx_push(8'h5A, 0, 0);
    rd(2'd1, v); chk("R5 full", v, 8'h18);
    rd(2'd0, v); chk("R5 data", v, 8'h5A);
    rd(2'd1, v); chk("R5 cleared", v, 8'h10);
    wr(2'd2, 8'h02);
    chk("R5 not ready", {7'd0, rx_ready_o}, 8'h00);
    rx_push(8'h77, 0, 0);
    wr(2'd2, 8'h03);
    rd(2'd1, v); chk("R5 dropped status", v, 8'h10);
    rd(2'd0, v); chk("R5 dropped data", v, 8'h5A);
  endtask

  task automatic t_err();
    logic [7:0] v;
    rx_push(8'h11, 1, 0);
    rd(2'd1, v); chk("R6 framing", v, 8'h1A);
    rx_push(8'h22, 0, 1);
    rd(2'd1, v); chk("R6 overrun parity", v, 8'h1D);
    rd(2'd0, v); chk("R6 data", v, 8'h22);
    rx_push(8'h33, 0, 0);
    rd(2'd1, v); chk("R6 overwritten", v, 8'h18);
    rd(2'd0, v);
    wr(2'd2, 8'hE3);
    rx_push(8'h44, 0, 0);
    rx_push(8'h55, 0, 0);
    rd(2'd1, v); chk("R6 overrun again", v, 8'h1C);
    wr(2'd1, 8'h5C);
    rd(2'd1, v); chk("R4 ovr cleared", v, 8'h18);
    rd(2'd2, v); chk("R4 command", v, 8'hE0);
    rd(2'd3, v); chk("R4 R2 control kept", v, 8'h9A);
    chk("R4 dtr", {7'd0, dtr_no}, 8'h01);
    chk("R4 rx ready", {7'd0, rx_ready_o}, 8'h00);
    rd(2'd0, v); chk("R4 byte kept", v, 8'h55);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr(2'd2, 8'h03);
    wr(2'd0, 8'hC3);
    chk("R7 valid", {7'd0, tx_valid_o}, 8'h01);
    chk("R7 data", tx_data_o, 8'hC3);
    rd(2'd1, v); chk("R7 busy", v, 8'h00);
    tx_take();
    chk("R7 valid off", {7'd0, tx_valid_o}, 8'h00);
    rd(2'd1, v); chk("R7 empty", v, 8'h10);
  endtask

  task automatic t_cts();
    logic [7:0] v;
    cts_ni = 1; idle(4);
    rd(2'd1, v); chk("R8 empty hidden", v, 8'h00);
    wr(2'd0, 8'h3C);
    idle(2);
    chk("R8 held", {7'd0, tx_valid_o}, 8'h00);
    cts_ni = 0; idle(4);
    chk("R8 resumed", {7'd0, tx_valid_o}, 8'h01);
    tx_take();
    rd(2'd1, v); chk("R8 empty shown", v, 8'h10);
  endtask

  task automatic t_rx_irq();
    logic [7:0] v;
    wr(2'd2, 8'h01);
    rx_push(8'hA5, 0, 0);
    idle(2);
    chk("R10 irq low", {7'd0, irq_no}, 8'h00);
    rd(2'd1, v); chk("R14 flag", v, 8'h98);
    rd(2'd0, v);
    idle(2);
    chk("R10 irq released", {7'd0, irq_no}, 8'h01);
    rd(2'd1, v); chk("R14 sticky", v, 8'h90);
    rd(2'd1, v); chk("R14 cleared", v, 8'h10);
  endtask

  task automatic t_tx_irq();
    logic [7:0] v;
    wr(2'd2, 8'h07);
    idle(2);
    chk("R11 irq low", {7'd0, irq_no}, 8'h00);
    wr(2'd0, 8'h81);
    idle(2);
    chk("R11 irq off busy", {7'd0, irq_no}, 8'h01);
    tx_take();
    idle(2);
    chk("R11 irq again", {7'd0, irq_no}, 8'h00);
    wr(2'd2, 8'h06);
    idle(2);
    chk("R13 master off", {7'd0, irq_no}, 8'h01);
    wr(2'd2, 8'h03);
    rd(2'd1, v);
  endtask

  task automatic t_line();
    logic [7:0] v;
    dcd_ni = 1; idle(6);
    chk("R12 dcd irq", {7'd0, irq_no}, 8'h00);
    rd(2'd1, v); chk("R12 R9 status", v, 8'hD0);
    idle(2);
    chk("R12 cleared", {7'd0, irq_no}, 8'h01);
    rd(2'd1, v); chk("R14 R9 after", v, 8'h50);
    dsr_ni = 1; idle(6);
    chk("R12 dsr irq", {7'd0, irq_no}, 8'h00);
    rd(2'd1, v); chk("R12 R9 dsr", v, 8'hF0);
    idle(2);
    wr(2'd2, 8'h02);
    dcd_ni = 0; idle(6);
    chk("R13 off edge", {7'd0, irq_no}, 8'h01);
    wr(2'd2, 8'h03);
    idle(4);
    chk("R13 forgotten", {7'd0, irq_no}, 8'h01);
    rd(2'd1, v); chk("R13 R9 status", v, 8'h30);
  endtask

  initial begin
    idle(3);
    rst_ni = 1;
    idle(4);
    t_reset();
    t_ctl();
    t_cmd();
    t_rx();
    t_err();
    t_tx();
    t_cts();
    t_rx_irq();
    t_tx_irq();
    t_line();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule